// File: doc/BRIEF.md
# Serial Video Link Word Aligner

This block sits behind the deserializing front end of a 7:1 serialized video link. It takes one sample per fast-clock cycle from every lane. Each channel has one forwarded-clock lane and four data lanes, and an optional second channel can be built in by parameter. From the forwarded-clock samples it finds where each 7-bit word begins. It then delivers one parallel 7-bit word per data lane once every word period.

Training runs as a chain of stages, and each stage has its own ready flag:

- PLL lock, taken from an external status bit.
- DDR synchronisation, which also needs an external status bit.
- Bit lock, once the clock lanes have stopped changing.
- Word lock, once the clock lane shows the expected pattern at a steady phase.
- Training done.

Losing PLL lock or DDR sync drops every later stage and starts training again.

A test mode checks the link payload. Each data lane must carry a 7-bit counter that steps by one on every word. Any step that breaks this sets a sticky error flag. Leaving test mode clears the flag.

Top module: `lvds_word_aligner`

## Requirements
- R1: After reset, every status output, the test error flag, `wordValid` and `wordOut` are 0.
- R2: `pllLock` is `pllLockIn` delayed by one cycle. `ddrReady` is `pllLock & ddrSyncIn`, registered one more cycle.
- R3: The block frames the samples into 7-sample windows. `bitLock` rises only while `ddrReady` is high, and only after 8 consecutive windows in which every clock lane's window equals the one before it. Any change restarts that count.
- R4: Once `bitLock` is high, channel 0's clock window is compared with the pattern 1100011, in arrival order, oldest sample first. This places the rising clock edge two bit times before word bit 0. `wordLock` rises after 4 consecutive matching windows.
- R5: Each window that fails the pattern compare moves the window boundary one sample later. Repeated failures step through all 7 phases modulo 7.
- R6: `trainDone` rises one cycle after `wordLock` and never before it.
- R7: While word-locked, `wordValid` pulses for one cycle per window. `wordOut[7*k +: 7]` is data lane k's word, and word bit i is the i-th sample to arrive in the window. Data lane index k = channel*4 + lane.
- R8: While `testModeEn` is high, each valid word on every data lane must equal that lane's previous valid word plus 1, modulo 128. A mismatch sets `testErr`, and the flag stays set while test mode stays on.
- R9: While `testModeEn` is low, `testErr` is 0 from the next cycle on. The first word after test mode is re-entered is not compared.
- R10: `pllLockIn` low, or `ddrSyncIn` low, clears `ddrReady`, `bitLock`, `wordLock` and `trainDone`. Training restarts when both are high again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast bit clock, one sample per lane per cycle |
| rstN | input | 1 | Asynchronous active-low reset |
| pllLockIn | input | 1 | External PLL lock status |
| ddrSyncIn | input | 1 | External DDR synchronisation status |
| testModeEn | input | 1 | Enables the counter-pattern compare |
| clkLaneIn | input | NUM_CH | Forwarded-clock lane samples, one per channel |
| dataLaneIn | input | NUM_CH*DATA_LANES | Data lane samples |
| wordOut | output | NUM_CH*DATA_LANES*7 | Aligned words, 7 bits per data lane |
| wordValid | output | 1 | One-cycle strobe marking a fresh `wordOut` |
| pllLock | output | 1 | Stage 1 ready |
| ddrReady | output | 1 | Stage 2 ready |
| bitLock | output | 1 | Stage 3 ready |
| wordLock | output | 1 | Stage 4 ready |
| trainDone | output | 1 | Training complete |
| testErr | output | 1 | Sticky test-mode mismatch flag |

## Verification
The flags have fixed latencies:
- `pllLock` follows its input by one cycle and `ddrReady` by two.
- A window completes on the edge that takes its seventh sample. The training flags change on the edge after that, and `wordOut` with `wordValid` appears on the edge after the window-end strobe.
- `trainDone` follows `wordLock` by one cycle.
- `testErr` follows the offending valid word by one cycle.

The bench runs a behavioural model that keeps the raw sample history in a queue. Each posedge it advances the model by these latencies. At every falling edge, halfway between active edges, it compares all outputs with the model. Directed checks then wait for more than the worst-case latency before they sample.

// File: rtl/lvds_align_pkg.sv
package lvds_align_pkg;

  localparam int WORD_BITS = 7;

  // Clock-lane window in arrival order (bit 0 = oldest sample).
  localparam logic [WORD_BITS-1:0] ALIGN_PATTERN = 7'b1100011;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_STABLE,
    ST_SEARCH,
    ST_LOCKED
  } trainState_t;

  typedef struct packed {
    logic slip;     // hold the bit counter for one sample
    logic capture;  // latch the current window as output words
  } ctrlStrobe_t;

endpackage

// File: rtl/lvds_align_datapath.sv
module lvds_align_datapath
  import lvds_align_pkg::*;
#(
  parameter int NUM_CH     = 2,
  parameter int DATA_LANES = 4,
  localparam int NDATA     = NUM_CH * DATA_LANES
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [NUM_CH-1:0]             clkLaneIn,
  input  logic [NDATA-1:0]              dataLaneIn,
  input  ctrlStrobe_t                   strobe,
  input  logic                          testModeEn,
  output logic                          winStrobe,
  output logic [NUM_CH*WORD_BITS-1:0]   clkWin,
  output logic [NDATA*WORD_BITS-1:0]    wordOut,
  output logic                          wordValid,
  output logic                          testErr
);

  localparam int CNT_W = $clog2(WORD_BITS);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_BITS - 1);

  logic [WORD_BITS-1:0] clkSh  [NUM_CH];
  logic [WORD_BITS-1:0] dataSh [NDATA];
  logic [CNT_W-1:0]     bitCnt;
  logic [NDATA*WORD_BITS-1:0] dataWin;
  logic [NDATA*WORD_BITS-1:0] prevWord;
  logic                       havePrev;
  logic                       mismatch;

  // Newest sample enters at the top; after 7 shifts the oldest sits in bit 0.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int c = 0; c < NUM_CH; c++) clkSh[c] <= '0;
      for (int l = 0; l < NDATA; l++) dataSh[l] <= '0;
    end else begin
      for (int c = 0; c < NUM_CH; c++) clkSh[c] <= {clkLaneIn[c], clkSh[c][WORD_BITS-1:1]};
      for (int l = 0; l < NDATA; l++) dataSh[l] <= {dataLaneIn[l], dataSh[l][WORD_BITS-1:1]};
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_clkWin
    assign clkWin[c*WORD_BITS +: WORD_BITS] = clkSh[c];
  end
  for (genvar l = 0; l < NDATA; l++) begin : g_dataWin
    assign dataWin[l*WORD_BITS +: WORD_BITS] = dataSh[l];
  end

  // Window framing; a slip holds the counter so the boundary moves one sample.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt    <= '0;
      winStrobe <= 1'b0;
    end else begin
      winStrobe <= (bitCnt == LAST_BIT) && !strobe.slip;
      if (!strobe.slip) bitCnt <= (bitCnt == LAST_BIT) ? '0 : bitCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wordOut   <= '0;
      wordValid <= 1'b0;
    end else begin
      wordValid <= strobe.capture;
      if (strobe.capture) wordOut <= dataWin;
    end
  end

  // Test mode: every lane must step by one per valid word.
  always_comb begin
    mismatch = 1'b0;
    for (int l = 0; l < NDATA; l++) begin
      if (wordOut[l*WORD_BITS +: WORD_BITS] != prevWord[l*WORD_BITS +: WORD_BITS] + 7'd1)
        mismatch = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      testErr  <= 1'b0;
      havePrev <= 1'b0;
      prevWord <= '0;
    end else if (!testModeEn) begin
      testErr  <= 1'b0;
      havePrev <= 1'b0;
    end else if (wordValid) begin
      if (havePrev && mismatch) testErr <= 1'b1;
      prevWord <= wordOut;
      havePrev <= 1'b1;
    end
  end

  assert_valid_gap_R7: assert property (@(posedge clk) disable iff (!rstN)
    wordValid |=> !wordValid);
  assert_err_clear_R9: assert property (@(posedge clk) disable iff (!rstN)
    !testModeEn |=> !testErr);
  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    (testErr && testModeEn) |=> testErr);

endmodule

// File: rtl/lvds_align_ctrl.sv
module lvds_align_ctrl
  import lvds_align_pkg::*;
#(
  parameter int NUM_CH         = 2,
  parameter int STABLE_WINDOWS = 8,
  parameter int LOCK_WINDOWS   = 4
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        pllLockIn,
  input  logic                        ddrSyncIn,
  input  logic                        winStrobe,
  input  logic [NUM_CH*WORD_BITS-1:0] clkWin,
  output ctrlStrobe_t                 strobe,
  output logic                        pllLock,
  output logic                        ddrReady,
  output logic                        bitLock,
  output logic                        wordLock,
  output logic                        trainDone
);

  localparam int STAB_W  = $clog2(STABLE_WINDOWS + 1);
  localparam int MATCH_W = $clog2(LOCK_WINDOWS + 1);

  trainState_t                 state;
  logic [STAB_W-1:0]           stableCnt;
  logic [MATCH_W-1:0]          matchCnt;
  logic [NUM_CH*WORD_BITS-1:0] prevWin;
  logic                        patOk;

  assign patOk          = (clkWin[WORD_BITS-1:0] == ALIGN_PATTERN);
  assign strobe.slip    = winStrobe && ddrReady && (state == ST_SEARCH) && !patOk;
  assign strobe.capture = winStrobe && (state == ST_LOCKED);

  assign bitLock  = (state == ST_SEARCH) || (state == ST_LOCKED);
  assign wordLock = (state == ST_LOCKED);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pllLock   <= 1'b0;
      ddrReady  <= 1'b0;
      trainDone <= 1'b0;
    end else begin
      pllLock   <= pllLockIn;
      ddrReady  <= pllLock && ddrSyncIn;
      trainDone <= wordLock && ddrReady;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      stableCnt <= '0;
      matchCnt  <= '0;
      prevWin   <= '0;
    end else if (!ddrReady) begin
      state     <= ST_IDLE;
      stableCnt <= '0;
      matchCnt  <= '0;
      prevWin   <= '0;
    end else if (winStrobe) begin
      unique case (state)
        ST_IDLE: begin
          prevWin   <= clkWin;
          stableCnt <= '0;
          state     <= ST_STABLE;
        end
        ST_STABLE: begin
          prevWin <= clkWin;
          if (clkWin != prevWin) begin
            stableCnt <= '0;
          end else if (int'(stableCnt) == STABLE_WINDOWS - 1) begin
            stableCnt <= '0;
            state     <= ST_SEARCH;
          end else begin
            stableCnt <= stableCnt + 1'b1;
          end
        end
        ST_SEARCH: begin
          if (!patOk) begin
            matchCnt <= '0;
          end else if (int'(matchCnt) == LOCK_WINDOWS - 1) begin
            matchCnt <= '0;
            state    <= ST_LOCKED;
          end else begin
            matchCnt <= matchCnt + 1'b1;
          end
        end
        default: state <= ST_LOCKED;
      endcase
    end
  end

  assert_bit_after_ddr_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(bitLock) |-> $past(ddrReady));
  assert_word_after_bit_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wordLock) |-> $past(bitLock));
  assert_no_slip_locked_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.slip |-> !wordLock);
  assert_done_after_word_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(trainDone) |-> $past(wordLock));
  assert_restart_R10: assert property (@(posedge clk) disable iff (!rstN)
    !pllLock |=> !ddrReady);

endmodule

// File: rtl/lvds_word_aligner.sv
module lvds_word_aligner
  import lvds_align_pkg::*;
#(
  parameter int NUM_CH         = 2,
  parameter int DATA_LANES     = 4,
  parameter int STABLE_WINDOWS = 8,
  parameter int LOCK_WINDOWS   = 4
) (
  input  logic                                   clk,
  input  logic                                   rstN,
  input  logic                                   pllLockIn,
  input  logic                                   ddrSyncIn,
  input  logic                                   testModeEn,
  input  logic [NUM_CH-1:0]                      clkLaneIn,
  input  logic [NUM_CH*DATA_LANES-1:0]           dataLaneIn,
  output logic [NUM_CH*DATA_LANES*WORD_BITS-1:0] wordOut,
  output logic                                   wordValid,
  output logic                                   pllLock,
  output logic                                   ddrReady,
  output logic                                   bitLock,
  output logic                                   wordLock,
  output logic                                   trainDone,
  output logic                                   testErr
);

  ctrlStrobe_t                 strobe;
  logic                        winStrobe;
  logic [NUM_CH*WORD_BITS-1:0] clkWin;

  lvds_align_datapath #(
    .NUM_CH    (NUM_CH),
    .DATA_LANES(DATA_LANES)
  ) datapath_i (
    .clk       (clk),
    .rstN      (rstN),
    .clkLaneIn (clkLaneIn),
    .dataLaneIn(dataLaneIn),
    .strobe    (strobe),
    .testModeEn(testModeEn),
    .winStrobe (winStrobe),
    .clkWin    (clkWin),
    .wordOut   (wordOut),
    .wordValid (wordValid),
    .testErr   (testErr)
  );

  lvds_align_ctrl #(
    .NUM_CH        (NUM_CH),
    .STABLE_WINDOWS(STABLE_WINDOWS),
    .LOCK_WINDOWS  (LOCK_WINDOWS)
  ) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .pllLockIn(pllLockIn),
    .ddrSyncIn(ddrSyncIn),
    .winStrobe(winStrobe),
    .clkWin   (clkWin),
    .strobe   (strobe),
    .pllLock  (pllLock),
    .ddrReady (ddrReady),
    .bitLock  (bitLock),
    .wordLock (wordLock),
    .trainDone(trainDone)
  );

endmodule

// File: tb/lvds_word_aligner_tb.sv
module lvds_word_aligner_tb_top;

  localparam int NCH   = 2;
  localparam int NDL   = 4;
  localparam int NDATA = NCH * NDL;
  localparam int NSMP  = NCH + NDATA;
  localparam logic [6:0] PAT = 7'b1100011;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pllLockIn = 1'b0, ddrSyncIn = 1'b0, testModeEn = 1'b0;
  logic [NCH-1:0]   clkLaneIn = '0;
  logic [NDATA-1:0] dataLaneIn = '0;
  logic [NDATA*7-1:0] wordOut;
  logic wordValid, pllLock, ddrReady, bitLock, wordLock, trainDone, testErr;

  always #5 clk = ~clk;

  lvds_word_aligner #(.NUM_CH(NCH), .DATA_LANES(NDL)) dut_i (
    .clk(clk), .rstN(rstN), .pllLockIn(pllLockIn), .ddrSyncIn(ddrSyncIn),
    .testModeEn(testModeEn), .clkLaneIn(clkLaneIn), .dataLaneIn(dataLaneIn),
    .wordOut(wordOut), .wordValid(wordValid), .pllLock(pllLock), .ddrReady(ddrReady),
    .bitLock(bitLock), .wordLock(wordLock), .trainDone(trainDone), .testErr(testErr)
  );

  int checks = 0, errors = 0;
  bit done = 0;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // ---------------- serializer stimulus ----------------
  int txPos = 3;           // start off the word boundary to force slips
  int txWord = 0;
  bit noise = 0, corruptReq = 0, corruptAct = 0;
  logic [15:0] lfsr = 16'hACE1;

  always @(negedge clk) begin
    logic [6:0] wv;
    if (txPos == 0 && corruptReq) begin corruptAct = 1; corruptReq = 0; end
    if (noise) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      clkLaneIn = lfsr[NCH-1:0];
    end else begin
      clkLaneIn = {NCH{PAT[txPos]}};
    end
    for (int l = 0; l < NDATA; l++) begin
      wv = 7'(txWord + l * 9);
      dataLaneIn[l] = wv[txPos] ^ (corruptAct && l == 0 && txPos == 3);
    end
    if (txPos == 6) begin txPos = 0; txWord++; corruptAct = 0; end
    else txPos++;
  end

  // ---------------- behavioural reference model ----------------
  logic [NSMP-1:0] hist[$];
  int mBitCnt, mState, mStable, mMatch;
  bit mPll, mDdr, mWinStb, mBw, mValid, mHave, mErr;
  logic [NCH*7-1:0]   mPrevWin;
  logic [NDATA*7-1:0] mWord, mPrevWord;

  function automatic logic [6:0] winOf(int lane);
    logic [6:0] w;
    for (int i = 0; i < 7; i++) w[i] = hist[i][lane];
    return w;
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hist.delete();
      for (int i = 0; i < 7; i++) hist.push_back('0);
      mBitCnt = 0; mState = 0; mStable = 0; mMatch = 0;
      mPll = 0; mDdr = 0; mWinStb = 0; mBw = 0; mValid = 0; mHave = 0; mErr = 0;
      mPrevWin = '0; mWord = '0; mPrevWord = '0;
    end else begin
      logic [NCH*7-1:0] cw;
      logic [NDATA*7-1:0] dw;
      bit sl, cap, mism;
      int nState, nStable, nMatch, nBitCnt;
      bit nErr, nHave, nWinStb, nBw, nValid;
      logic [NCH*7-1:0] nPrevWin;
      logic [NDATA*7-1:0] nWord, nPrevWord;
      for (int c = 0; c < NCH; c++) cw[c*7 +: 7] = winOf(c);
      for (int l = 0; l < NDATA; l++) dw[l*7 +: 7] = winOf(NCH + l);
      sl  = mWinStb && mDdr && mState == 2 && cw[6:0] != PAT;
      cap = mWinStb && mState == 3;
      // test compare
      nErr = mErr; nHave = mHave; nPrevWord = mPrevWord;
      if (!testModeEn) begin nErr = 0; nHave = 0; end
      else if (mValid) begin
        mism = 0;
        for (int l = 0; l < NDATA; l++)
          if (mWord[l*7 +: 7] != 7'(mPrevWord[l*7 +: 7] + 1)) mism = 1;
        if (mHave && mism) nErr = 1;
        nPrevWord = mWord; nHave = 1;
      end
      nWord = cap ? dw : mWord;
      nValid = cap;
      nWinStb = (mBitCnt == 6) && !sl;
      nBitCnt = sl ? mBitCnt : (mBitCnt == 6 ? 0 : mBitCnt + 1);
      nBw = (mState == 3) && mDdr;
      nState = mState; nStable = mStable; nMatch = mMatch; nPrevWin = mPrevWin;
      if (!mDdr) begin nState = 0; nStable = 0; nMatch = 0; nPrevWin = '0; end
      else if (mWinStb) begin
        if (mState == 0) begin nPrevWin = cw; nStable = 0; nState = 1; end
        else if (mState == 1) begin
          nPrevWin = cw;
          if (cw != mPrevWin) nStable = 0;
          else if (mStable == 7) begin nStable = 0; nState = 2; end
          else nStable = mStable + 1;
        end else if (mState == 2) begin
          if (cw[6:0] != PAT) nMatch = 0;
          else if (mMatch == 3) begin nMatch = 0; nState = 3; end
          else nMatch = mMatch + 1;
        end
      end
      mDdr = mPll && ddrSyncIn;
      mPll = pllLockIn;
      hist.push_back({dataLaneIn, clkLaneIn});
      void'(hist.pop_front());
      mBitCnt = nBitCnt; mWinStb = nWinStb; mState = nState; mStable = nStable;
      mMatch = nMatch; mPrevWin = nPrevWin; mBw = nBw; mValid = nValid; mWord = nWord;
      mErr = nErr; mHave = nHave; mPrevWord = nPrevWord;
    end
  end

  // Compare every cycle, half a period away from the active edge.
  always @(negedge clk) begin
    if (rstN && !done) begin
      check(pllLock == mPll, "R2 pllLock", pllLock, mPll);
      check(ddrReady == mDdr, "R2 ddrReady", ddrReady, mDdr);
      check(bitLock == (mState >= 2), "R3 bitLock", bitLock, mState >= 2);
      check(wordLock == (mState == 3), "R4 wordLock", wordLock, mState == 3);
      check(trainDone == mBw, "R6 trainDone", trainDone, mBw);
      check(wordValid == mValid, "R7 wordValid", wordValid, mValid);
      check(wordOut == mWord, "R7 wordOut", wordOut[63:0], mWord[63:0]);
      check(testErr == mErr, "R8 testErr", testErr, mErr);
    end
  end

  task automatic waitCycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic waitLock(input int maxCycles);
    for (int i = 0; i < maxCycles && !wordLock; i++) @(negedge clk);
  endtask

  task automatic checkLaneSpacing(input string req);
    @(negedge clk);
    while (!wordValid) @(negedge clk);
    check(wordOut[13:7] == 7'(wordOut[6:0] + 9), req, wordOut[13:7], 7'(wordOut[6:0] + 9));
  endtask

  task automatic checkStep(input string req);
    logic [6:0] first;
    while (!wordValid) @(negedge clk);
    first = wordOut[6:0];
    @(negedge clk);
    while (!wordValid) @(negedge clk);
    check(wordOut[6:0] == 7'(first + 1), req, wordOut[6:0], 7'(first + 1));
  endtask

  initial begin
    waitCycles(5);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    check({pllLock, ddrReady, bitLock, wordLock, trainDone, testErr, wordValid} == '0,
          "R1 flags", {pllLock, ddrReady, bitLock, wordLock, trainDone, testErr, wordValid}, 0);
    check(wordOut == '0, "R1 wordOut", wordOut[63:0], 0);

    pllLockIn = 1'b1;
    waitCycles(100);
    check(bitLock == 1'b0, "R3 no bitLock without ddrReady", bitLock, 0);

    ddrSyncIn = 1'b1;
    waitLock(600);
    check(wordLock == 1'b1, "R4 word lock reached", wordLock, 1);
    checkStep("R5 boundary found after slips");
    checkLaneSpacing("R7 lane order");
    check(trainDone == 1'b1, "R6 trainDone after wordLock", trainDone, 1);

    testModeEn = 1'b1;
    waitCycles(60);
    check(testErr == 1'b0, "R8 clean counter", testErr, 0);
    corruptReq = 1;
    waitCycles(40);
    check(testErr == 1'b1, "R8 mismatch flagged", testErr, 1);
    waitCycles(40);
    check(testErr == 1'b1, "R8 flag sticky", testErr, 1);
    testModeEn = 1'b0;
    waitCycles(2);
    check(testErr == 1'b0, "R9 cleared when off", testErr, 0);

    pllLockIn = 1'b0;
    waitCycles(4);
    check({ddrReady, bitLock, wordLock, trainDone} == '0, "R10 flags cleared",
          {ddrReady, bitLock, wordLock, trainDone}, 0);
    pllLockIn = 1'b1;
    noise = 1;
    waitCycles(200);
    check(bitLock == 1'b0, "R3 unstable clock lane blocks bitLock", bitLock, 0);
    noise = 0;
    waitLock(600);
    check(wordLock == 1'b1, "R10 retrained", wordLock, 1);

    ddrSyncIn = 1'b0;
    waitCycles(3);
    check({bitLock, wordLock, trainDone} == '0, "R10 ddr loss clears", {bitLock, wordLock, trainDone}, 0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule